// File: doc/BRIEF.md
# Gated Ring Oscillator Time-to-Digital Readout

This block turns the raw observations of a gated ring oscillator into one signed phase-error word per reference cycle. The ring is stopped between measurement windows instead of being reset, so its phase carries over from one window to the next. The block keeps a running absolute phase count, and each output word is the change in that count since the previous measurement. Because the quantization residue of one window is carried into the next, the resulting error sequence has first-order noise shaping.

The ring's stages are grouped into cells. Each cell has its own wrap counter, advanced by a per-cell strobe from the analog side, and its own fine decoder, which reads the sampled logic levels of that cell's stages. On the measurement-done strobe, the block adds the coarse and fine contributions of all cells into an absolute phase modulo 2^W. It subtracts the previously captured phase and presents the two's complement difference, with a one-cycle valid flag, on the next clock.

Top module: `grotdc_readout`

## Requirements
- R1: While synchronous reset is applied, and on the first cycle after it, `err_valid_o` is 0 and `err_o` is 0.
- R2: The NSTAGE stages are split into NCELL consecutive cells starting from stage 0. Every cell holds floor(NSTAGE/NCELL) stages, and the first NSTAGE mod NCELL cells hold one more. With the defaults (47, 7) the cells hold 7,7,7,7,7,6,6 stages.
- R3: A cell of length L whose highest stage reads 0 decodes to the number of consecutive 1s counted upward from its lowest stage. If its highest stage reads 1, it decodes to L plus the number of consecutive 0s counted upward from its lowest stage. The result lies in 0..2L-1.
- R4: A cell pattern with more than one level change is decoded by the same rule, which stops counting at the first stage that equals the highest stage. Any stage pattern therefore yields a code in 0..2L-1.
- R5: Each cell's wrap counter increases by one in every clock cycle in which that cell's strobe is high, including the cycle of a measurement. The measurement includes that increment. Otherwise the counter keeps its value, and only reset clears it.
- R6: The absolute phase is the sum over all cells of (2L x wrap count + fine code), taken modulo 2^W.
- R7: On a clock edge where `meas_done_i` is high, the block captures the phase. From the next cycle, `err_o` holds the new phase minus the previously captured phase, modulo 2^W, read as signed two's complement. The result is correct across wraps of the phase register.
- R8: The first measurement after reset leaves `err_valid_o` low but stores its phase. Every later measurement raises `err_valid_o` for exactly one cycle.
- R9: In cycles where `meas_done_i` is low, `ring_state_i` has no effect. `err_o` keeps its value, `err_valid_o` stays low, and the next result depends only on the stage levels present at the next measurement.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_state_i | input | NSTAGE | Sampled logic level of every ring stage |
| cell_wrap_i | input | NCELL | Per-cell wrap strobe, one count per high cycle |
| meas_done_i | input | 1 | End of measurement window; capture on this edge |
| err_o | output | W | Signed phase-error word, two's complement |
| err_valid_o | output | 1 | One-cycle flag marking a fresh `err_o` |

## Verification
The assertions take for granted that each cell strobe reports at most one wrap per clock. They also assume that no cell is longer than 64 stages, so the fine decoder covers it. The stimulus applies at most one strobe per cell per cycle. It mixes random stage vectors, which include many multi-transition patterns, with clean thermometer codes produced by a bench-side ring phase model. It uses random gaps between measurements and keeps the default cell geometry. One directed stretch drives long strobe runs, so the absolute phase register wraps several times between captures.

// File: rtl/grotdc_pkg.sv
package grotdc_pkg;

  // first stage index of cell c when n stages are split into k cells
  function automatic int unsigned cell_start(input int unsigned n, input int unsigned k,
                                             input int unsigned c);
    int unsigned base;
    int unsigned extra;
    base  = n / k;
    extra = n % k;
    return c * base + ((c < extra) ? c : extra);
  endfunction

  // number of stages in cell c
  function automatic int unsigned cell_len(input int unsigned n, input int unsigned k,
                                           input int unsigned c);
    return (n / k) + ((c < (n % k)) ? 1 : 0);
  endfunction

  // fine position inside a cell: run of stages differing from the top stage,
  // counted from the bottom; offset by len when the top stage is high
  function automatic int unsigned fine_pos(input logic [63:0] s, input int unsigned len);
    logic        top;
    logic        run;
    int unsigned k;
    top = s[len-1];
    run = 1'b1;
    k   = 0;
    for (int i = 0; i < 64; i++) begin
      if (run && (i < int'(len) - 1) && (s[i] != top)) k = k + 1;
      else run = 1'b0;
    end
    return top ? (len + k) : k;
  endfunction

  // modular difference, caller truncates to its word width
  function automatic logic [31:0] wrap_sub(input logic [31:0] cur, input logic [31:0] prev);
    return cur - prev;
  endfunction

endpackage

// File: rtl/grotdc_cell.sv
module grotdc_cell
  import grotdc_pkg::*;
#(
  parameter int unsigned LEN = 7,
  parameter int unsigned W   = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wrap_i,
  input  logic [LEN-1:0] state_i,
  output logic [W-1:0]   phase_o
);

  localparam logic [W-1:0] STEP = W'(2 * LEN);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_eff;
  logic [63:0]  state_ext;
  logic [W-1:0] pos_w;

  assign cnt_eff   = cnt_q + W'(wrap_i);
  assign state_ext = 64'(state_i);
  assign pos_w     = W'(fine_pos(state_ext, LEN));
  assign phase_o   = cnt_eff * STEP + pos_w;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_eff;
  end

  // counter moves only on a strobe (R5)
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(cnt_q));

  // a strobe advances by exactly one (R5)
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> (cnt_q == $past(cnt_q) + W'(1)));

  // fine code stays inside the cell range, any pattern (R3, R4)
  p_fine_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_w < STEP));

endmodule

// File: rtl/grotdc_sum.sv
module grotdc_sum #(
  parameter int unsigned NCELL = 7,
  parameter int unsigned W     = 11
) (
  input  logic [NCELL-1:0][W-1:0] parts_i,
  output logic [W-1:0]            total_o
);

  always_comb begin
    total_o = '0;
    for (int c = 0; c < int'(NCELL); c++) total_o = total_o + parts_i[c];
  end

endmodule

// File: rtl/grotdc_readout.sv
module grotdc_readout
  import grotdc_pkg::*;
#(
  parameter int unsigned NSTAGE = 47,
  parameter int unsigned NCELL  = 7,
  parameter int unsigned W      = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSTAGE-1:0]   ring_state_i,
  input  logic [NCELL-1:0]    cell_wrap_i,
  input  logic                meas_done_i,
  output logic signed [W-1:0] err_o,
  output logic                err_valid_o
);

  logic [NCELL-1:0][W-1:0] cell_phase;
  logic [W-1:0]            total_w;
  logic [W-1:0]            delta_w;
  logic [W-1:0]            phase_q;
  logic [W-1:0]            err_q;
  logic                    valid_q;
  logic                    primed_q;
  logic                    chk_armed_q;

  for (genvar c = 0; c < int'(NCELL); c++) begin : g_cell
    localparam int unsigned ST = cell_start(NSTAGE, NCELL, c);
    localparam int unsigned LN = cell_len(NSTAGE, NCELL, c);
    grotdc_cell #(.LEN(LN), .W(W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_i  (cell_wrap_i[c]),
      .state_i (ring_state_i[ST +: LN]),
      .phase_o (cell_phase[c])
    );
  end

  grotdc_sum #(.NCELL(NCELL), .W(W)) u_sum (
    .parts_i (cell_phase),
    .total_o (total_w)
  );

  assign delta_w = W'(wrap_sub(32'(total_w), 32'(phase_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= '0;
      err_q       <= '0;
      valid_q     <= 1'b0;
      primed_q    <= 1'b0;
      chk_armed_q <= 1'b0;
    end else begin
      chk_armed_q <= 1'b1;
      valid_q     <= 1'b0;
      if (meas_done_i) begin
        phase_q  <= total_w;
        err_q    <= delta_w;
        valid_q  <= primed_q;
        primed_q <= 1'b1;
      end
    end
  end

  assign err_o       = signed'(err_q);
  assign err_valid_o = valid_q;

  // a valid word follows a capture edge (R7)
  p_valid_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_o |-> $past(meas_done_i));

  // reported word equals the step of the stored phase (R6, R7)
  p_delta_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed_q && err_valid_o) |-> (err_q == W'(phase_q - $past(phase_q))));

  // the capture that arms the block reports nothing (R8)
  p_first_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_q) |-> !err_valid_o);

  // without a capture the output is frozen (R9)
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed_q && !$past(meas_done_i)) |-> ($stable(err_q) && !err_valid_o));

endmodule

// File: tb/grotdc_readout_tb.sv
`timescale 1ns/1ps
module grotdc_readout_tb;

  localparam int unsigned NS = 47;
  localparam int unsigned NC = 7;
  localparam int unsigned W  = 11;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NS-1:0]       ring_state = '0;
  logic [NC-1:0]       cell_wrap = '0;
  logic                meas_done = 1'b0;
  logic signed [W-1:0] err;
  logic                err_valid;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  int unsigned cnt_m [NC];
  logic [W-1:0] prev_m;
  bit           primed_m;
  logic [W-1:0] last_err;

  always #4 clk = ~clk;

  grotdc_readout #(.NSTAGE(NS), .NCELL(NC), .W(W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ring_state_i (ring_state),
    .cell_wrap_i  (cell_wrap),
    .meas_done_i  (meas_done),
    .err_o        (err),
    .err_valid_o  (err_valid)
  );

  // geometry restated: lengths by cell, start by accumulation (R2)
  function automatic int unsigned m_len(input int unsigned c);
    int unsigned l;
    l = NS / NC;
    if (c < NS % NC) l++;
    return l;
  endfunction

  // position by locating the first stage equal to the top one (R3, R4)
  function automatic int unsigned m_pos(input logic [NS-1:0] st, input int unsigned b,
                                        input int unsigned l);
    logic top;
    int unsigned first;
    top = st[b + l - 1];
    first = l - 1;
    for (int i = int'(l) - 1; i >= 0; i--) if (st[b + i] == top) first = i;
    return top ? l + first : first;
  endfunction

  function automatic logic [W-1:0] m_phase(input logic [NS-1:0] st);
    int unsigned b;
    longint unsigned acc;
    b = 0;
    acc = 0;
    for (int c = 0; c < int'(NC); c++) begin
      acc += longint'(cnt_m[c]) * 2 * m_len(c) + m_pos(st, b, m_len(c));
      b += m_len(c);
    end
    return W'(acc);
  endfunction

  // clean thermometer state for given per-cell positions
  function automatic logic [NS-1:0] m_encode(input int unsigned p [NC]);
    logic [NS-1:0] st;
    int unsigned b;
    b = 0;
    st = '0;
    for (int c = 0; c < int'(NC); c++) begin
      for (int i = 0; i < int'(m_len(c)); i++) begin
        if (p[c] < m_len(c)) st[b + i] = (i < int'(p[c]));
        else                 st[b + i] = !(i < int'(p[c] - m_len(c)));
      end
      b += m_len(c);
    end
    return st;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [NS-1:0] st, input logic [NC-1:0] inc, input bit dn,
                     input string req);
    logic [W-1:0] cur;
    logic [W-1:0] exp_e;
    @(negedge clk);
    ring_state = st;
    cell_wrap  = inc;
    meas_done  = dn;
    for (int c = 0; c < int'(NC); c++) if (inc[c]) cnt_m[c]++;
    @(posedge clk);
    #1;
    if (dn) begin
      cur = m_phase(st);
      if (primed_m) begin
        exp_e = cur - prev_m;
        check(err_valid == 1'b1, {req, " R8 valid"}, err_valid, 1);
        check(err == signed'(exp_e), {req, " R7 err"}, err, signed'(exp_e));
      end else begin
        check(err_valid == 1'b0, {req, " R8 first"}, err_valid, 0);
      end
      prev_m   = cur;
      primed_m = 1'b1;
      last_err = err;
    end else begin
      check(err_valid == 1'b0 && err == signed'(last_err), {req, " R9 hold"},
            err, signed'(last_err));
    end
  endtask

  initial begin
    int unsigned p [NC];
    logic [NS-1:0] st;
    void'($urandom(32'd1357));
    for (int c = 0; c < int'(NC); c++) cnt_m[c] = 0;
    primed_m = 0;
    last_err = '0;
    repeat (3) @(posedge clk);
    #1;
    check(err_valid == 1'b0 && err == 0, "R1 in reset", err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(err_valid == 1'b0 && err == 0, "R1 after reset", err, 0);

    // first capture silent, second one from a clean model
    for (int c = 0; c < int'(NC); c++) p[c] = 0;
    cyc(m_encode(p), '0, 1'b1, "R8");
    for (int c = 0; c < int'(NC); c++) p[c] = c + 1;
    cyc(m_encode(p), '0, 1'b1, "R3 thermo");

    // top stage high in every cell, positions above L
    for (int c = 0; c < int'(NC); c++) p[c] = m_len(c) + (c % 3);
    cyc(m_encode(p), '0, 1'b1, "R3 upper half");

    // multi-transition patterns: cell 0 = 7'b0100101, all others alternating (R4)
    st = {NS{1'b0}};
    st[6:0] = 7'b0100101;
    for (int i = 7; i < int'(NS); i++) st[i] = i[0];
    cyc(st, '0, 1'b1, "R4 clamp");

    // strobe in the capture cycle is included (R5)
    cyc(st, 7'b1010101, 1'b1, "R5 same cycle");
    cyc(st, 7'b0000001, 1'b0, "R5 between");
    cyc(st, 7'b1000000, 1'b1, "R5 counted");

    // state changes without capture are ignored (R9)
    cyc({$urandom, $urandom}, '0, 1'b0, "R9 idle a");
    cyc({$urandom, $urandom}, '0, 1'b0, "R9 idle b");
    for (int c = 0; c < int'(NC); c++) p[c] = (2 * m_len(c)) - 1;
    cyc(m_encode(p), '0, 1'b1, "R9 latest only");

    // long strobe runs wrap the phase register (R6)
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 120; k++) cyc(m_encode(p), 7'h7f, 1'b0, "R6 run");
      cyc(m_encode(p), 7'h7f, 1'b1, "R6 wrap");
    end

    // ring model advancing a random amount per window (R2, R3, R5, R7)
    for (int w = 0; w < 150; w++) begin
      int unsigned gap;
      gap = 1 + ($urandom % 6);
      for (int g = 0; g < int'(gap); g++) begin
        logic [NC-1:0] inc;
        inc = '0;
        for (int c = 0; c < int'(NC); c++) begin
          p[c] = p[c] + ($urandom % 3);
          if (p[c] >= 2 * m_len(c)) begin
            p[c] = p[c] - 2 * m_len(c);
            inc[c] = 1'b1;
          end
        end
        cyc(m_encode(p), inc, (g == int'(gap) - 1), "R2 model");
      end
    end

    // random vectors and strobes (R4, R6, R7)
    for (int k = 0; k < 600; k++)
      cyc({$urandom, $urandom}, NC'($urandom), ($urandom % 3) == 0, "R6 random");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule